// File: doc/BRIEF.md
# Ordered Address Decoder Register Bank

This block holds a row of programmable host-address decoder slots behind a simple 32-bit word-addressed register port. Every slot keeps a 64-bit base, a 64-bit size, a control word and a 64-bit routing word. On a switch-style slot the routing word is a list of eight 8-bit port identifiers, with way i in byte i (bits 8i+7:8i). On an endpoint-style slot it is a skip length. Software fills in a slot and then sets its commit bit. After a fixed validation time the slot reports either committed or a commit error.

Slots may only become committed in ascending index order. A slot whose size is zero never commits. A committed slot whose lock bit is set ignores every write until reset. Clearing the commit bit takes an unlocked slot back to the uncommitted state, after which software zeroes base and size. A read-only capability word reports the slot count, the target count and two interleave-support flags. Routing of requests and interleave arithmetic live elsewhere; this block only stores the configuration and runs the commit handshake.

Word map: word 0 is the capability word. Slot s occupies words 8(s+1) to 8(s+1)+7, with these offsets: 0 base low, 1 base high, 2 size low, 3 size high, 4 control, 5 routing low, 6 routing high. Offset 7 and any unmapped word read as zero.

Control word bits:
- bit 0: commit request
- bit 1: lock
- bit 2: target type (1 = memory expander, 0 = accelerator)
- bit 3: committed (read only)
- bit 4: commit error (read only)
- bits 11:8: ways code
- bits 15:12: granularity code

All other control bits read as zero.

Top module: `dec_bank`

## Requirements
- R1: After reset every slot register reads zero, and `slot_committed` and `slot_error` are all zero.
- R2: Base, size and routing words are written and read back as separate low and high 32-bit words at offsets 0/1, 2/3 and 5/6. For the routing word, byte i of the 64-bit value (bits 8i+7:8i) holds way i. Read data appears one clock after `rd_en`.
- R3: A control write that sets bit 0 while the stored commit bit is 0 starts validation. If the slot is valid, `slot_committed` rises exactly COMMIT_LAT clocks after the write edge.
- R4: A slot s>0 whose slot s-1 is not committed when validation ends raises `slot_error` instead of committed. Committed never rises on slot s unless slot s-1 is already committed.
- R5: A slot whose size is zero when validation ends raises `slot_error` instead of committed.
- R6: A control write with bit 0 clear on an unfrozen slot clears both committed and error, and aborts a pending validation, at the next edge.
- R7: While a slot is committed with lock (bit 1) set, all writes to that slot are ignored, including a control write that clears bit 0.
- R8: Capability word 0 reads {14'b0, bit17 = bits 14:12 interleave supported, bit16 = bits 11:8 interleave supported, bits 15:8 = target count, bits 7:0 = slot count}.
- R9: The control word reads back its stored bits 0, 1, 2 and 15:8, with bit 3 = committed and bit 4 = error. All other bits read zero.
- R10: Lock has no effect on an uncommitted slot: its registers still accept writes.
- R11: A slot is never committed and in error at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Registered read data, valid one clock after rd_en |
| slot_committed | output | NUM_SLOTS | Per-slot committed flag |
| slot_error | output | NUM_SLOTS | Per-slot commit error flag |

## Verification
The commit handshake is exercised with four patterns:
- a commit on slot 1 before slot 0, which separates the ordering check from the plain latency path;
- a zero-size commit on slot 0, which isolates the size check;
- an in-order valid sequence, which checks the exact latency;
- a commit cleared mid-validation, which shows the abort path.

Locking is tried twice: on a committed slot, where base and control writes must vanish, and on an uncommitted slot, where they must land. A behavioural model driven by the same inputs predicts both flag vectors on every clock and every read word. This separates timing slips from decode and field errors.

// File: rtl/dec_bank_pkg.sv
package dec_bank_pkg;
  localparam int OFF_BASE_LO  = 0;
  localparam int OFF_BASE_HI  = 1;
  localparam int OFF_SIZE_LO  = 2;
  localparam int OFF_SIZE_HI  = 3;
  localparam int OFF_CTRL     = 4;
  localparam int OFF_ROUTE_LO = 5;
  localparam int OFF_ROUTE_HI = 6;

  localparam int CB_COMMIT  = 0;
  localparam int CB_LOCK    = 1;
  localparam int CB_TYPE    = 2;
  localparam int CB_DONE    = 3;
  localparam int CB_ERR     = 4;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_FF07;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_BUSY = 2'd1,
    CS_OK   = 2'd2,
    CS_BAD  = 2'd3
  } commit_state_t;
endpackage

// File: rtl/dec_slot_regs.sv
module dec_slot_regs
  import dec_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_hit,
  input  logic [2:0]  wr_off,
  input  logic [31:0] wr_data,
  input  logic        frozen,
  input  logic [2:0]  rd_off,
  input  logic        committed,
  input  logic        error,
  output logic        commit_bit,
  output logic        lock_bit,
  output logic        size_zero,
  output logic [31:0] rd_word
);
  logic [63:0] base_q, size_q, route_q;
  logic [31:0] ctrl_q;
  logic        accept;

  assign accept = wr_hit && !frozen;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      size_q  <= '0;
      route_q <= '0;
      ctrl_q  <= '0;
    end else if (accept) begin
      case (wr_off)
        3'(OFF_BASE_LO):  base_q[31:0]   <= wr_data;
        3'(OFF_BASE_HI):  base_q[63:32]  <= wr_data;
        3'(OFF_SIZE_LO):  size_q[31:0]   <= wr_data;
        3'(OFF_SIZE_HI):  size_q[63:32]  <= wr_data;
        3'(OFF_CTRL):     ctrl_q         <= wr_data & CTRL_KEEP_MASK;
        3'(OFF_ROUTE_LO): route_q[31:0]  <= wr_data;
        3'(OFF_ROUTE_HI): route_q[63:32] <= wr_data;
        default: ;
      endcase
    end
  end

  assign commit_bit = ctrl_q[CB_COMMIT];
  assign lock_bit   = ctrl_q[CB_LOCK];
  assign size_zero  = (size_q == 64'd0);

  always_comb begin
    rd_word = '0;
    case (rd_off)
      3'(OFF_BASE_LO):  rd_word = base_q[31:0];
      3'(OFF_BASE_HI):  rd_word = base_q[63:32];
      3'(OFF_SIZE_LO):  rd_word = size_q[31:0];
      3'(OFF_SIZE_HI):  rd_word = size_q[63:32];
      3'(OFF_CTRL): begin
        rd_word         = ctrl_q;
        rd_word[CB_DONE] = committed;
        rd_word[CB_ERR]  = error;
      end
      3'(OFF_ROUTE_LO): rd_word = route_q[31:0];
      3'(OFF_ROUTE_HI): rd_word = route_q[63:32];
      default:          rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dec_commit_fsm.sv
module dec_commit_fsm
  import dec_bank_pkg::*;
#(
  parameter int COMMIT_LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  input  logic size_zero,
  input  logic prev_ok,
  output logic committed,
  output logic error
);
  localparam int CNT_W = (COMMIT_LAT < 2) ? 1 : $clog2(COMMIT_LAT);

  commit_state_t state_q;
  logic [CNT_W-1:0] cnt_q;
  logic valid_now;

  assign valid_now = !size_zero && prev_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else if (stop) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= CS_BUSY;
      cnt_q   <= '0;
    end else if (state_q == CS_BUSY) begin
      if (cnt_q == CNT_W'(COMMIT_LAT - 1)) begin
        state_q <= valid_now ? CS_OK : CS_BAD;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign committed = (state_q == CS_OK);
  assign error     = (state_q == CS_BAD);
endmodule

// File: rtl/dec_bank.sv
module dec_bank
  import dec_bank_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int NUM_TARGETS  = 8,
  parameter int ADDR_W       = 8,
  parameter int COMMIT_LAT   = 4,
  parameter bit INTLV_LO_OK  = 1'b1,
  parameter bit INTLV_HI_OK  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  output logic [NUM_SLOTS-1:0] slot_committed,
  output logic [NUM_SLOTS-1:0] slot_error
);
  localparam int SEL_W = ADDR_W - 3;
  localparam logic [31:0] CAP_WORD = {14'd0, INTLV_HI_OK, INTLV_LO_OK,
                                      8'(NUM_TARGETS), 8'(NUM_SLOTS)};

  logic [SEL_W-1:0] wr_sel, rd_sel;
  logic [2:0]       wr_off, rd_off;
  logic [NUM_SLOTS-1:0] commit_vec, lock_vec, zero_vec, frozen_vec;
  logic [31:0] slot_rword [NUM_SLOTS];
  logic [31:0] rd_next;

  assign wr_sel = wr_addr[ADDR_W-1:3];
  assign wr_off = wr_addr[2:0];
  assign rd_sel = rd_addr[ADDR_W-1:3];
  assign rd_off = rd_addr[2:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit, ctrl_wr, start, stop, prev_ok;

    assign hit     = wr_en && (wr_sel == SEL_W'(s + 1));
    assign ctrl_wr = hit && (wr_off == 3'(OFF_CTRL)) && !frozen_vec[s];
    assign start   = ctrl_wr && wr_data[CB_COMMIT] && !commit_vec[s];
    assign stop    = ctrl_wr && !wr_data[CB_COMMIT];
    assign frozen_vec[s] = slot_committed[s] && lock_vec[s];

    if (s == 0) begin : g_first
      assign prev_ok = 1'b1;
    end else begin : g_chain
      assign prev_ok = slot_committed[s-1];
    end

    dec_slot_regs u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_hit     (hit),
      .wr_off     (wr_off),
      .wr_data    (wr_data),
      .frozen     (frozen_vec[s]),
      .rd_off     (rd_off),
      .committed  (slot_committed[s]),
      .error      (slot_error[s]),
      .commit_bit (commit_vec[s]),
      .lock_bit   (lock_vec[s]),
      .size_zero  (zero_vec[s]),
      .rd_word    (slot_rword[s])
    );

    dec_commit_fsm #(.COMMIT_LAT(COMMIT_LAT)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .stop      (stop),
      .size_zero (zero_vec[s]),
      .prev_ok   (prev_ok),
      .committed (slot_committed[s]),
      .error     (slot_error[s])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == '0) rd_next = CAP_WORD;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_sel == SEL_W'(s + 1)) rd_next = slot_rword[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/dec_bank_chk.sv
module dec_bank_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [31:0]          wr_data,
  input logic [NUM_SLOTS-1:0] slot_committed,
  input logic [NUM_SLOTS-1:0] slot_error,
  input logic [NUM_SLOTS-1:0] slot_lock
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (slot_committed == '0 && slot_error == '0));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    (slot_committed & slot_error) == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_p
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'((s + 1) * 8 + 4));

    a_r6_decommit: assert property (@(posedge clk) disable iff (rst)
      (ctrl_hit && !wr_data[0] && !(slot_committed[s] && slot_lock[s]))
      |=> (!slot_committed[s] && !slot_error[s]));

    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
      (wr_en && slot_committed[s] && slot_lock[s])
      |=> (slot_committed[s] && $stable(slot_lock[s])));

    if (s > 0) begin : g_ord
      a_r4_in_order: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_committed[s]) |-> $past(slot_committed[s-1]));
    end
  end
endmodule

bind dec_bank dec_bank_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .slot_committed (slot_committed),
  .slot_error     (slot_error),
  .slot_lock      (lock_vec)
);

// File: tb/dec_bank_tb.sv
`timescale 1ns/1ps
module dec_bank_tb_top;
  localparam int N   = 4;
  localparam int AW  = 8;
  localparam int LAT = 4;
  localparam int NT  = 8;
  localparam logic [31:0] CAP = {14'd0, 1'b0, 1'b1, 8'(NT), 8'(N)};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] slot_committed, slot_error;

  always #5 clk = ~clk;

  dec_bank #(.NUM_SLOTS(N), .NUM_TARGETS(NT), .ADDR_W(AW), .COMMIT_LAT(LAT),
             .INTLV_LO_OK(1'b1), .INTLV_HI_OK(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .slot_committed(slot_committed), .slot_error(slot_error));

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference: 0 idle, 1 validating, 2 committed, 3 error
  int          st  [N];
  int          cnt [N];
  logic [63:0] mb  [N], ms [N], mr [N];
  logic [31:0] mc  [N];
  logic [31:0] exp_rd = '0;

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    int idx, off;
    logic [31:0] w;
    if (a == 0) return CAP;
    idx = int'(a) / 8 - 1;
    off = int'(a) % 8;
    if (idx < 0 || idx >= N) return 32'd0;
    case (off)
      0: w = mb[idx][31:0];
      1: w = mb[idx][63:32];
      2: w = ms[idx][31:0];
      3: w = ms[idx][63:32];
      4: w = mc[idx] | ((st[idx] == 2) ? 32'h8 : 32'h0) | ((st[idx] == 3) ? 32'h10 : 32'h0);
      5: w = mr[idx][31:0];
      6: w = mr[idx][63:32];
      default: w = 32'd0;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    int nst [N];
    int ncnt [N];
    if (rst) begin
      for (int s = 0; s < N; s++) begin
        st[s] = 0; cnt[s] = 0; mb[s] = 0; ms[s] = 0; mr[s] = 0; mc[s] = 0;
      end
      exp_rd = 0;
    end else begin
      if (rd_en) exp_rd = mread(rd_addr);
      for (int s = 0; s < N; s++) begin
        bit frozen, hit, cw, ok;
        frozen = (st[s] == 2) && mc[s][1];
        hit = wr_en && (int'(wr_addr) / 8 == s + 1);
        cw = hit && (int'(wr_addr) % 8 == 4) && !frozen;
        nst[s] = st[s]; ncnt[s] = cnt[s];
        if (st[s] == 1) begin
          if (cnt[s] == LAT - 1) begin
            ok = (ms[s] != 0) && (s == 0 || st[s-1] == 2);
            nst[s] = ok ? 2 : 3; ncnt[s] = 0;
          end else ncnt[s] = cnt[s] + 1;
        end
        if (cw && wr_data[0] && !mc[s][0]) begin nst[s] = 1; ncnt[s] = 0; end
        if (cw && !wr_data[0]) begin nst[s] = 0; ncnt[s] = 0; end
      end
      for (int s = 0; s < N; s++) begin
        bit frozen;
        frozen = (st[s] == 2) && mc[s][1];
        if (wr_en && int'(wr_addr) / 8 == s + 1 && !frozen) begin
          case (int'(wr_addr) % 8)
            0: mb[s][31:0]  = wr_data;
            1: mb[s][63:32] = wr_data;
            2: ms[s][31:0]  = wr_data;
            3: ms[s][63:32] = wr_data;
            4: mc[s]        = wr_data & 32'h0000_FF07;
            5: mr[s][31:0]  = wr_data;
            6: mr[s][63:32] = wr_data;
            default: ;
          endcase
        end
      end
      for (int s = 0; s < N; s++) begin st[s] = nst[s]; cnt[s] = ncnt[s]; end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of flags and read data against the model
  logic rd_pend = 1'b0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [N-1:0] ec, ee;
      for (int s = 0; s < N; s++) begin
        ec[s] = (st[s] == 2);
        ee[s] = (st[s] == 3);
      end
      check("R3 committed vs model", 64'(slot_committed), 64'(ec));
      check("R4 error vs model", 64'(slot_error), 64'(ee));
      check("R11 never both", 64'(slot_committed & slot_error), 64'd0);
      if (rd_pend) check("R2 read vs model", 64'(rd_data), 64'(exp_rd));
    end
    rd_pend = rd_en;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, 64'(rd_data), 64'(e));
  endtask

  function automatic int sa(input int s, input int off);
    return (s + 1) * 8 + off;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R8 capability
    check("R1 flags after reset", 64'({slot_committed, slot_error}), 64'd0);
    rd_expect(0, CAP, "R8 capability word");
    rd_expect(sa(0, 4), 32'd0, "R1 slot0 ctrl zero");
    rd_expect(sa(2, 6), 32'd0, "R1 slot2 route hi zero");

    // R4 out-of-order commit on slot 1
    wr(sa(1, 2), 32'h1000);
    wr(sa(1, 4), 32'h1);
    repeat (LAT) @(negedge clk);
    check("R4 slot1 error", 64'(slot_error[1]), 64'd1);
    rd_expect(sa(1, 4), 32'h11, "R9 ctrl shows error");
    wr(sa(1, 4), 32'h0);
    check("R6 error cleared", 64'({slot_committed[1], slot_error[1]}), 64'd0);

    // R5 zero-size commit on slot 0
    wr(sa(0, 4), 32'h1);
    repeat (LAT) @(negedge clk);
    check("R5 zero size error", 64'({slot_committed[0], slot_error[0]}), 64'b01);
    wr(sa(0, 4), 32'h0);

    // R2/R3 valid commit of slot 0
    wr(sa(0, 0), 32'h4000_0000);
    wr(sa(0, 1), 32'h0000_0002);
    wr(sa(0, 2), 32'h1000_0000);
    wr(sa(0, 3), 32'h0);
    wr(sa(0, 5), 32'h03_02_01_00);
    wr(sa(0, 6), 32'h07_06_05_04);
    wr(sa(0, 4), 32'h0000_1205);
    repeat (LAT - 1) @(negedge clk);
    check("R3 not yet committed", 64'(slot_committed[0]), 64'd0);
    @(negedge clk);
    check("R3 committed after latency", 64'(slot_committed[0]), 64'd1);
    rd_expect(sa(0, 1), 32'h2, "R2 base hi");
    rd_expect(sa(0, 5), 32'h03020100, "R2 route way0..3");
    rd_expect(sa(0, 6), 32'h07060504, "R2 route way4..7");
    rd_expect(sa(0, 4), 32'h0000_120D, "R9 ctrl readback committed");

    // slot 1 now in order
    wr(sa(1, 4), 32'h5);
    repeat (LAT) @(negedge clk);
    check("R4 in-order slot1 commit", 64'(slot_committed[1]), 64'd1);

    // R7 lock freezes slot 0
    wr(sa(0, 4), 32'h0000_1207);
    wr(sa(0, 0), 32'hDEAD_BEEF);
    rd_expect(sa(0, 0), 32'h4000_0000, "R7 base write ignored");
    wr(sa(0, 4), 32'h0);
    check("R7 decommit ignored", 64'(slot_committed[0]), 64'd1);
    rd_expect(sa(0, 4), 32'h0000_120F, "R7 ctrl unchanged");

    // R10 lock on uncommitted slot 2
    wr(sa(2, 4), 32'h2);
    wr(sa(2, 2), 32'h0000_0040);
    rd_expect(sa(2, 2), 32'h40, "R10 write accepted");

    // R6 abort pending validation on slot 2
    wr(sa(2, 4), 32'h1);
    wr(sa(2, 4), 32'h0);
    repeat (LAT + 1) @(negedge clk);
    check("R6 aborted no commit", 64'({slot_committed[2], slot_error[2]}), 64'd0);

    // R6 decommit slot 1 and software zeroing
    wr(sa(1, 4), 32'h0);
    check("R6 slot1 decommitted", 64'(slot_committed[1]), 64'd0);
    wr(sa(1, 2), 32'h0);
    rd_expect(sa(1, 2), 32'h0, "R6 size zeroed");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule